// File: doc/BRIEF.md
# Two-Share Masked 4-bit Substitution Pipeline

This block evaluates the 4-bit substitution box of a lightweight substitution-permutation cipher on a nibble that is held as two Boolean shares. The true input nibble is the XOR of the two input shares, and the true output nibble is the XOR of the two output shares. The unshared value never exists on any wire. The substitution is factored into a per-share input affine map, two passes of a quadratic function G, and a per-share output affine map. Each G pass is split into two halves separated by a register. The first half combines only terms from one share. The second half adds the terms that mix the shares. Because of this split, no single combinational cone ever sees both shares of the same variable.

A serial cipher datapath feeds the block one shared nibble per clock, with a valid flag. It collects the shared result four clocks later. The affine constants are split between the shares by two parameters, so the sharing of the constants can be chosen per instance.

For reference, the unmasked mapping of inputs 0 through F is C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.

Top module: `sbox2_pipe`

## Requirements
- R1: When `out_valid` is high, `out_sh0 ^ out_sh1` equals the substitution of `in_sh0 ^ in_sh1`, taken from the inputs sampled four rising edges earlier. The mapping for inputs 0..F is C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2, with bit 3 as the most significant bit.
- R2: `out_valid` follows `in_valid` with a fixed delay of exactly four rising clock edges.
- R3: The block accepts a new nibble on every clock. A run of N consecutive valid inputs produces a run of N consecutive valid outputs.
- R4: On the rising edge that samples `rst` high, all pipeline state clears. Directly after that edge, `out_valid`, `out_sh0` and `out_sh1` are all 0.
- R5: A cycle in which `in_valid` is low produces a cycle in which `out_valid` is low, four edges later. Valid items on either side of that cycle keep their place and their value.
- R6: A reset applied while items are in flight discards all of them. No valid output appears for any input presented before or during the reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input shares carry an item this cycle |
| in_sh0 | input | 4 | Input share 0 |
| in_sh1 | input | 4 | Input share 1 |
| out_valid | output | 1 | The output shares carry a result this cycle |
| out_sh0 | output | 4 | Output share 0 |
| out_sh1 | output | 4 | Output share 1 |

## Verification
Each result is due four rising edges after the edge that samples its input. This holds for both the valid flag and the recombined data, and the reset clearing is visible right after the edge that samples reset. The bench drives inputs on falling edges and keeps an eight-slot record indexed by its own cycle count. At each falling edge it compares the outputs with the slot written four cycles earlier, before it drives the next input. All 256 share pairs are applied back to back, followed by a bubble pattern and a mid-stream reset that marks the in-flight slots as discarded.

// File: rtl/sbox2_pkg.sv
package sbox2_pkg;

    localparam int NIB_W    = 4;
    localparam int N_SHARES = 2;

    // constants added before the first and after the last G pass
    localparam logic [NIB_W-1:0] SBOX_C = 4'b0001;
    localparam logic [NIB_W-1:0] SBOX_D = 4'b0101;

    typedef logic [NIB_W-1:0]               nib_t;
    typedef logic [N_SHARES-1:0][NIB_W-1:0] share_t;

    // stage after a same-share half: partial result plus the G inputs
    typedef struct packed {
        logic   vld;
        share_t part;
        share_t inp;
    } half_t;

    // stage holding a complete shared nibble
    typedef struct packed {
        logic   vld;
        share_t val;
    } full_t;

    typedef struct packed {
        half_t s1;
        full_t s2;
        half_t s3;
        full_t s4;
    } pipe_t;

    // bit order of a nibble: [3]=x, [2]=y, [1]=z, [0]=w
    function automatic nib_t mat_b(input nib_t i);
        nib_t o;
        o[3] = i[3] ^ i[2];
        o[2] = i[2] ^ i[1];
        o[1] = i[1];
        o[0] = i[2] ^ i[0];
        return o;
    endfunction

    function automatic nib_t mat_a(input nib_t i);
        nib_t o;
        o[3] = i[3] ^ i[1];
        o[2] = i[2];
        o[1] = i[3];
        o[0] = i[3] ^ i[1] ^ i[0];
        return o;
    endfunction

    // quadratic terms formed from one share only
    function automatic nib_t g_same(input nib_t v);
        nib_t o;
        o[3] = v[3] ^ (v[2] & v[1]) ^ (v[2] & v[0]);
        o[2] = v[0] ^ (v[3] & v[2]);
        o[1] = v[2];
        o[0] = v[1] ^ (v[2] & v[0]);
        return o;
    endfunction

    // mixed terms: own y with the other share's x, z, w
    function automatic nib_t g_cross(input nib_t own, input nib_t oth);
        nib_t o;
        o[3] = (own[2] & oth[1]) ^ (own[2] & oth[0]);
        o[2] = oth[3] & own[2];
        o[1] = 1'b0;
        o[0] = own[2] & oth[0];
        return o;
    endfunction

endpackage

// File: rtl/sbox2_lin_in.sv
module sbox2_lin_in
    import sbox2_pkg::*;
#(
    parameter nib_t K0 = 4'h0,
    parameter nib_t K1 = 4'h1
) (
    input  share_t x_i,
    output share_t y_o
);
    localparam share_t KEYS = {K1, K0};

    for (genvar k = 0; k < N_SHARES; k++) begin : g_share
        assign y_o[k] = mat_b(x_i[k]) ^ KEYS[k];
    end
endmodule

// File: rtl/sbox2_g_first.sv
module sbox2_g_first
    import sbox2_pkg::*;
(
    input  share_t v_i,
    output share_t h_o
);
    for (genvar k = 0; k < N_SHARES; k++) begin : g_share
        assign h_o[k] = g_same(v_i[k]);
    end
endmodule

// File: rtl/sbox2_g_second.sv
module sbox2_g_second
    import sbox2_pkg::*;
(
    input  share_t v_i,
    input  share_t h_i,
    output share_t g_o
);
    for (genvar k = 0; k < N_SHARES; k++) begin : g_share
        localparam int OTHER = N_SHARES - 1 - k;
        assign g_o[k] = h_i[k] ^ g_cross(v_i[k], v_i[OTHER]);
    end
endmodule

// File: rtl/sbox2_lin_out.sv
module sbox2_lin_out
    import sbox2_pkg::*;
#(
    parameter nib_t K0 = 4'h0,
    parameter nib_t K1 = 4'h5
) (
    input  share_t x_i,
    output share_t y_o
);
    localparam share_t KEYS = {K1, K0};

    for (genvar k = 0; k < N_SHARES; k++) begin : g_share
        assign y_o[k] = mat_a(x_i[k]) ^ KEYS[k];
    end
endmodule

// File: rtl/sbox2_pipe.sv
module sbox2_pipe
    import sbox2_pkg::*;
#(
    parameter logic [3:0] C_SPLIT0 = 4'h9,
    parameter logic [3:0] D_SPLIT0 = 4'h6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [3:0] in_sh0,
    input  logic [3:0] in_sh1,
    output logic       out_valid,
    output logic [3:0] out_sh0,
    output logic [3:0] out_sh1
);
    localparam nib_t C_SPLIT1 = SBOX_C ^ C_SPLIT0;
    localparam nib_t D_SPLIT1 = SBOX_D ^ D_SPLIT0;

    pipe_t  pipe_d, pipe_q;
    share_t bx, h1, g1, h2, g2, ay;

    // pass 1, same-share half, fed from the input affine map
    sbox2_lin_in #(.K0(C_SPLIT0), .K1(C_SPLIT1)) u_lin_in (
        .x_i ({in_sh1, in_sh0}),
        .y_o (bx)
    );
    sbox2_g_first u_g1_first (
        .v_i (bx),
        .h_o (h1)
    );

    // pass 1, cross-share half
    sbox2_g_second u_g1_second (
        .v_i (pipe_q.s1.inp),
        .h_i (pipe_q.s1.part),
        .g_o (g1)
    );

    // pass 2, same-share half
    sbox2_g_first u_g2_first (
        .v_i (pipe_q.s2.val),
        .h_o (h2)
    );

    // pass 2, cross-share half merged with the output affine map
    sbox2_g_second u_g2_second (
        .v_i (pipe_q.s3.inp),
        .h_i (pipe_q.s3.part),
        .g_o (g2)
    );
    sbox2_lin_out #(.K0(D_SPLIT0), .K1(D_SPLIT1)) u_lin_out (
        .x_i (g2),
        .y_o (ay)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1.vld  = in_valid;
        pipe_d.s1.part = h1;
        pipe_d.s1.inp  = bx;
        pipe_d.s2.vld  = pipe_q.s1.vld;
        pipe_d.s2.val  = g1;
        pipe_d.s3.vld  = pipe_q.s2.vld;
        pipe_d.s3.part = h2;
        pipe_d.s3.inp  = pipe_q.s2.val;
        pipe_d.s4.vld  = pipe_q.s3.vld;
        pipe_d.s4.val  = ay;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s4.vld;
    assign out_sh0   = pipe_q.s4.val[0];
    assign out_sh1   = pipe_q.s4.val[1];

endmodule

// File: rtl/sbox2_check.sv
module sbox2_check (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [3:0] in_sh0,
    input logic [3:0] in_sh1,
    input logic       out_valid,
    input logic [3:0] out_sh0,
    input logic [3:0] out_sh1
);
    logic [2:0] warm_q;
    logic       rst_seen_q;
    logic       warm;

    function automatic logic [3:0] ref_sbox(input logic [3:0] v);
        case (v)
            4'h0: return 4'hC;  4'h1: return 4'h5;
            4'h2: return 4'h6;  4'h3: return 4'hB;
            4'h4: return 4'h9;  4'h5: return 4'h0;
            4'h6: return 4'hA;  4'h7: return 4'hD;
            4'h8: return 4'h3;  4'h9: return 4'hE;
            4'hA: return 4'hF;  4'hB: return 4'h8;
            4'hC: return 4'h4;  4'hD: return 4'h7;
            4'hE: return 4'h1;  default: return 4'h2;
        endcase
    endfunction

    // counts edges since reset so that depth-4 history is meaningful
    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 3'd4) begin
            warm_q <= warm_q + 3'd1;
        end
    end
    assign warm = (warm_q == 3'd4);

    p_unmasked_value_r1: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |->
            ((out_sh0 ^ out_sh1) == ref_sbox($past(in_sh0 ^ in_sh1, 4))));

    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_valid, 4)) |-> out_valid);

    p_bubble_kept_r5: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(in_valid, 4)) |-> !out_valid);

    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (!warm) |-> !out_valid);

    always @(negedge clk) begin
        if (rst_seen_q) begin
            p_reset_clear_r4: assert (!out_valid && out_sh0 == 4'h0 && out_sh1 == 4'h0);
        end
    end

endmodule

bind sbox2_pipe sbox2_check i_sbox2_check (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sh0    (in_sh0),
    .in_sh1    (in_sh1),
    .out_valid (out_valid),
    .out_sh0   (out_sh0),
    .out_sh1   (out_sh1)
);

// File: tb/test_sbox2_pipe.sv
module test_sbox2_pipe;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_sh0 = 4'h0;
    logic [3:0] in_sh1 = 4'h0;
    logic       out_valid;
    logic [3:0] out_sh0;
    logic [3:0] out_sh1;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int run_len  = 0;
    int max_run  = 0;
    logic zero_chk = 1'b0;

    logic       rv [8];
    logic       rk [8];
    logic [3:0] rx [8];

    localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                       4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};

    always #2 clk = ~clk;

    sbox2_pipe i_sbox2_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sh0    (in_sh0),
        .in_sh1    (in_sh1),
        .out_valid (out_valid),
        .out_sh0   (out_sh0),
        .out_sh1   (out_sh1)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // falling edge: check the item due now, then drive the next one
    task automatic step(input logic r, input logic v, input logic [3:0] a, input logic [3:0] b);
        int e;
        @(negedge clk);
        e = (cyc + 4) % 8;
        if (zero_chk) begin
            check("R4 valid after reset", int'(out_valid), 0);
            check("R4 shares after reset", int'({out_sh1, out_sh0}), 0);
            zero_chk = 1'b0;
        end
        if (rv[e]) begin
            check("R2 valid delay", int'(out_valid), 1);
            check("R1 unmasked value", int'(out_sh0 ^ out_sh1), int'(rx[e]));
        end else if (rk[e]) begin
            check("R6 discarded by reset", int'(out_valid), 0);
        end else begin
            check("R5 bubble", int'(out_valid), 0);
        end
        if (out_valid) begin
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
        rst      = r;
        in_valid = v;
        in_sh0   = a;
        in_sh1   = b;
        if (r) begin
            for (int j = 0; j < 4; j++) begin
                rv[(cyc + 8 - j) % 8] = 1'b0;
                rk[(cyc + 8 - j) % 8] = 1'b1;
            end
            zero_chk = 1'b1;
        end else begin
            rv[cyc % 8] = v;
            rk[cyc % 8] = 1'b0;
            rx[cyc % 8] = SB[a ^ b];
        end
        cyc++;
    endtask

    initial begin
        #(4 * 100000);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int j = 0; j < 8; j++) begin
            rv[j] = 1'b0;
            rk[j] = 1'b0;
            rx[j] = 4'h0;
        end
        for (int j = 0; j < 3; j++) step(1'b1, 1'b0, 4'h0, 4'h0);

        // R1, R3: every share pair, back to back
        max_run = 0;
        for (int i = 0; i < 256; i++) step(1'b0, 1'b1, 4'(i >> 4), 4'(i));
        for (int j = 0; j < 5; j++) step(1'b0, 1'b0, 4'h0, 4'h0);
        check("R3 back-to-back run length", max_run, 256);

        // R5: bubbles mixed into a stream
        for (int i = 0; i < 48; i++)
            step(1'b0, (i % 3) != 0, 4'(i * 7), 4'(i * 5 + 3));

        // R6: reset while the pipeline is full
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 4'(i + 2), 4'(11 - i));
        step(1'b1, 1'b1, 4'hA, 4'h3);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 4'(i * 3), 4'(i + 9));
        for (int j = 0; j < 6; j++) step(1'b0, 1'b0, 4'h0, 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule